// File: doc/BRIEF.md
# Dual Down-Counter Timer with Shared Bus Window

The block places two identical down-counting timers behind one 4 KB register window on a simple word bus. The lower 64 bytes of the window are split into two 32-byte timer register sets. The top 32 bytes hold a fixed table of eight read-only identification bytes. Every other offset reads as zero, and writes to it have no effect. The test-control offsets 0xF00 and 0xF04 are among these zero offsets.

Each timer counts on its own tick-enable input, so the two can run at different rates; both are meant to run from a 1 MHz enable by default. A timer can be free-running, periodic or one-shot. It has a 1, 16 or 256 step prescaler and a 16-bit or 32-bit counter width. It keeps a raw interrupt level, which an enable bit masks. The masked levels of the two timers are ORed onto one interrupt output. Read data is registered and appears one cycle after the request, marked by a valid strobe.

Top module: `dual_timer_wrap`

## Requirements
- R1: Byte offsets 0x00-0x1F address timer 0. Offsets 0x20-0x3F address timer 1, with 0x20 subtracted. Inside a timer: 0x00 load, 0x04 current count, 0x08 control, 0x0C interrupt clear (write only), 0x10 raw interrupt (bit 0), 0x14 masked interrupt (bit 0), 0x18 background load. Offset 0x1C reads zero.
- R2: Word reads of 0xFE0, 0xFE4, ..., 0xFFC return, in address order, 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with the upper bits zero.
- R3: `irq_any` is high exactly when at least one timer has its raw interrupt set and its interrupt-enable bit set.
- R4: Every offset outside the two timer ranges and the ID table reads zero, including 0xF00 and 0xF04. A write to any offset outside the two timer ranges, the ID table included, changes nothing that can be read back.
- R5: A timer steps only on cycles where its own tick-enable input is high. The other timer's tick input has no effect on it.
- R6: A read request returns its data on `rd_data` with `rd_valid` high in the next cycle. `rd_valid` is low in every cycle that does not follow a read request.
- R7: Writing the load register sets the reload value and restarts the count from it. Writing the background load register changes only the reload value. Writes to the count register are ignored.
- R8: While enabled, each counting step decrements the count. A step taken at count zero sets the raw interrupt and reloads, so one period is (reload + 1) steps. A bus write to a timer replaces that timer's tick in the same cycle.
- R9: Control bit 0 = one-shot, bit 6 = periodic, bit 1 = 32-bit width, bit 7 = enable. With bits 0 and 6 both clear, the timer is free-running and reloads 0xFFFF, or 0xFFFFFFFF when bit 1 is set. In one-shot mode the step at zero clears bit 7 and holds the count at zero.
- R10: Control bits 3:2 pick the prescale. The value 1 gives one step per 16 ticks, the value 2 gives one step per 256 ticks, and 0 or 3 give one step per tick. A control write restarts the prescaler and, when bit 7 is set, reloads the count.
- R11: Control bit 5 is the interrupt enable. After reset the control register reads 0x20 and all other timer registers read zero. A write to the interrupt-clear register clears the raw interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_wdata | input | DATA_W | Write data |
| tick_en0 | input | 1 | Count-rate enable for timer 0 |
| tick_en1 | input | 1 | Count-rate enable for timer 1 |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid strobe |
| irq_any | output | 1 | OR of both masked timer interrupts |

## Verification
The checker watches these on every cycle:
- the interrupt output agrees with each timer's raw level and enable bit;
- `rd_valid` follows read requests by exactly one cycle;
- a clear write drops timer 0's raw level;
- the first ID byte and the test-control offsets read back as fixed values.

Only the bench's scenarios can show the rest:
- the full window map, read after reset and again after a flood of stray writes;
- reload arithmetic and period length;
- the three prescale rates;
- one-shot stopping and both free-running widths;
- the independence of the two tick inputs.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
   localparam int NUM_TMR = 2;

   localparam logic [2:0] RI_LOAD = 3'd0;
   localparam logic [2:0] RI_COUNT = 3'd1;
   localparam logic [2:0] RI_CTRL = 3'd2;
   localparam logic [2:0] RI_ICLR = 3'd3;
   localparam logic [2:0] RI_RAW = 3'd4;
   localparam logic [2:0] RI_MASK = 3'd5;
   localparam logic [2:0] RI_BGLD = 3'd6;

   localparam int B_ONESHOT = 0;
   localparam int B_WIDE = 1;
   localparam int B_DIV_LO = 2;
   localparam int B_DIV_HI = 3;
   localparam int B_IE = 5;
   localparam int B_PERIODIC = 6;
   localparam int B_ENABLE = 7;

   localparam logic [7:0] CTL_RESET = 8'h20;

   function automatic logic [7:0] ident_byte(input logic [2:0] idx);
      case (idx)
         3'd0: ident_byte = 8'h04;
         3'd1: ident_byte = 8'h18;
         3'd2: ident_byte = 8'h14;
         3'd3: ident_byte = 8'h00;
         3'd4: ident_byte = 8'h0D;
         3'd5: ident_byte = 8'hF0;
         3'd6: ident_byte = 8'h05;
         default: ident_byte = 8'hB1;
      endcase
   endfunction
endpackage

// File: rtl/dtw_decode.sv
module dtw_decode #(
   parameter int ADDR_W = 12,
   parameter int NUM_TMR = 2
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_TMR-1:0] tmr_hit,
   output logic               id_hit,
   output logic [2:0]         word_idx
);
   localparam int BLK_W = ADDR_W - 5;

   logic [BLK_W-1:0] blk;
   logic unused_lsb;

   assign blk = addr[ADDR_W-1:5];
   assign word_idx = addr[4:2];
   assign id_hit = &blk;
   assign unused_lsb = ^addr[1:0];

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_hit
      assign tmr_hit[t] = (blk == BLK_W'(t));
   end
endmodule

// File: rtl/dtw_id_rom.sv
module dtw_id_rom
   import dtw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        idx,
   output logic [DATA_W-1:0] word
);
   assign word = DATA_W'(ident_byte(idx));
endmodule

// File: rtl/dtw_timer_core.sv
module dtw_timer_core
   import dtw_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W = 32,
   parameter int NARROW_W = 16,
   parameter int DIV_MID_LOG2 = 4,
   parameter int DIV_HI_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [2:0]        reg_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word,
   output logic              irq_raw,
   output logic              ie_out,
   output logic              irq_masked
);
   localparam int PRE_W = DIV_HI_LOG2;
   localparam logic [PRE_W-1:0] TERM_MID = PRE_W'((1 << DIV_MID_LOG2) - 1);
   localparam logic [PRE_W-1:0] TERM_HI = '1;
   localparam logic [CNT_W-1:0] MAX_WIDE = '1;
   localparam logic [CNT_W-1:0] MAX_NARROW = CNT_W'({NARROW_W{1'b1}});

   logic [DATA_W-1:0] lim_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [7:0]        ctl_q;
   logic              raw_q;
   logic [PRE_W-1:0]  pre_q;

   function automatic logic [CNT_W-1:0] reload_val(input logic [7:0] c,
                                                   input logic [DATA_W-1:0] l);
      if (!c[B_ONESHOT] && !c[B_PERIODIC])
         reload_val = c[B_WIDE] ? MAX_WIDE : MAX_NARROW;
      else if (c[B_WIDE])
         reload_val = l[CNT_W-1:0];
      else
         reload_val = CNT_W'(l[NARROW_W-1:0]);
   endfunction

   function automatic logic [PRE_W-1:0] term_of(input logic [7:0] c);
      case (c[B_DIV_HI:B_DIV_LO])
         2'd1: term_of = TERM_MID;
         2'd2: term_of = TERM_HI;
         default: term_of = '0;
      endcase
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q <= '0;
         cnt_q <= '0;
         ctl_q <= CTL_RESET;
         raw_q <= 1'b0;
         pre_q <= '0;
      end else if (wr_en) begin
         case (reg_idx)
            RI_LOAD: begin
               lim_q <= wdata;
               cnt_q <= reload_val(ctl_q, wdata);
            end
            RI_CTRL: begin
               ctl_q <= wdata[7:0];
               pre_q <= '0;
               if (wdata[B_ENABLE]) cnt_q <= reload_val(wdata[7:0], lim_q);
            end
            RI_ICLR: raw_q <= 1'b0;
            RI_BGLD: lim_q <= wdata;
            default: ;
         endcase
      end else if (ctl_q[B_ENABLE] && tick_en) begin
         if (pre_q != term_of(ctl_q)) begin
            pre_q <= pre_q + 1'b1;
         end else begin
            pre_q <= '0;
            if (cnt_q == '0) begin
               raw_q <= 1'b1;
               if (ctl_q[B_ONESHOT]) ctl_q[B_ENABLE] <= 1'b0;
               else cnt_q <= reload_val(ctl_q, lim_q);
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (reg_idx)
         RI_LOAD, RI_BGLD: rd_word = lim_q;
         RI_COUNT: rd_word = DATA_W'(cnt_q);
         RI_CTRL: rd_word = DATA_W'(ctl_q);
         RI_RAW: rd_word = DATA_W'(raw_q);
         RI_MASK: rd_word = DATA_W'(raw_q & ctl_q[B_IE]);
         default: rd_word = '0;
      endcase
   end

   assign irq_raw = raw_q;
   assign ie_out = ctl_q[B_IE];
   assign irq_masked = raw_q & ctl_q[B_IE];
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
   import dtw_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W = 32,
   parameter int NARROW_W = 16,
   parameter int DIV_MID_LOG2 = 4,
   parameter int DIV_HI_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              tick_en0,
   input  logic              tick_en1,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              irq_any
);
   if (ADDR_W != 12) begin : g_bad_aw
      $error("window must span 4 KB");
   end
   if (CNT_W > DATA_W || NARROW_W >= CNT_W) begin : g_bad_cw
      $error("counter widths inconsistent");
   end
   if (DIV_MID_LOG2 >= DIV_HI_LOG2 || DIV_MID_LOG2 < 1) begin : g_bad_div
      $error("prescale exponents inconsistent");
   end

   logic              rd_req, wr_req;
   logic [NUM_TMR-1:0] tmr_hit, tick_vec, raw_vec, ie_vec, mask_vec;
   logic              id_hit;
   logic [2:0]        word_idx;
   logic [DATA_W-1:0] tmr_word [NUM_TMR];
   logic [DATA_W-1:0] id_word, rd_next;

   assign rd_req = bus_sel && !bus_wr;
   assign wr_req = bus_sel && bus_wr;
   assign tick_vec = {tick_en1, tick_en0};

   dtw_decode #(.ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR)) u_dec (
      .addr(bus_addr), .tmr_hit(tmr_hit), .id_hit(id_hit), .word_idx(word_idx)
   );

   dtw_id_rom #(.DATA_W(DATA_W)) u_id (.idx(word_idx), .word(id_word));

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      dtw_timer_core #(
         .DATA_W(DATA_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W),
         .DIV_MID_LOG2(DIV_MID_LOG2), .DIV_HI_LOG2(DIV_HI_LOG2)
      ) u_core (
         .clk(clk), .rst_n(rst_n), .tick_en(tick_vec[t]),
         .wr_en(wr_req && tmr_hit[t]), .reg_idx(word_idx), .wdata(bus_wdata),
         .rd_word(tmr_word[t]), .irq_raw(raw_vec[t]), .ie_out(ie_vec[t]),
         .irq_masked(mask_vec[t])
      );
   end

   always_comb begin
      rd_next = '0;
      for (int t = 0; t < NUM_TMR; t++)
         if (tmr_hit[t]) rd_next = tmr_word[t];
      if (id_hit) rd_next = id_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= rd_next;
      end
   end

   assign irq_any = |mask_vec;
endmodule

// File: rtl/dtw_checker.sv
module dtw_checker #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int NT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              irq_any,
   input logic [NT-1:0]     raw_vec,
   input logic [NT-1:0]     ie_vec
);
   // R3: combined line agrees with each timer's raw level and enable
   a_r3_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == |(raw_vec & ie_vec));

   // R11: no raw level means no interrupt
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_vec == '0) |-> !irq_any);

   // R11: clear write to timer 0 drops its raw level
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(12'h00C)) |=> !raw_vec[0]);

   // R6: read data strobe one cycle after a request
   a_r6_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr) |=> rd_valid);

   // R6: no strobe without a request
   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> !rd_valid);

   // R2: first identification byte
   a_r2_id_first: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(12'hFE0)) |=> rd_data == DATA_W'(8'h04));

   // R4: test-control offsets read zero
   a_r4_test_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && (bus_addr == ADDR_W'(12'hF00) || bus_addr == ADDR_W'(12'hF04)))
      |=> rd_data == '0);
endmodule

bind dual_timer_wrap dtw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NT(2)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .rd_data(rd_data), .rd_valid(rd_valid), .irq_any(irq_any),
   .raw_vec(raw_vec), .ie_vec(ie_vec)
);

// File: tb/dual_timer_wrap_test.sv
module dual_timer_wrap_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic tick_en0 = 1'b0, tick_en1 = 1'b0;
   logic [31:0] rd_data;
   logic rd_valid, irq_any;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_timer_wrap uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tick_en0(tick_en0),
      .tick_en1(tick_en1), .rd_data(rd_data), .rd_valid(rd_valid), .irq_any(irq_any)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0;
      d = rd_data;
      chk("R6 valid", 32'(rd_valid), 32'd1);
   endtask

   task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic ticks(input int which, input int n);
      if (which == 0) tick_en0 = 1'b1; else tick_en1 = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick_en0 = 1'b0; tick_en1 = 1'b0;
   endtask

   // expected value of every offset just after reset (R1 R2 R4 R11)
   function automatic logic [31:0] reset_view(input int a);
      int w = a >> 2;
      if (w < 16) return ((w & 7) == 2) ? 32'h20 : 32'h0;
      if (w >= 1016) begin
         case (w - 1016)
            0: return 32'h04; 1: return 32'h18; 2: return 32'h14; 3: return 32'h00;
            4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
         endcase
      end
      return 32'h0;
   endfunction

   task automatic sweep(input string tag);
      for (int a = 0; a < 4096; a += 4) rdchk(tag, 12'(a), reset_view(a));
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R11 irq after reset", 32'(irq_any), 32'd0);
      chk("R6 idle valid", 32'(rd_valid), 32'd0);
      sweep("R1/R2/R4 map after reset");
      for (int a = 64; a < 4096; a += 4) wr(12'(a), 32'hFFFF_FFFF);
      sweep("R4 map after stray writes");

      // R1 timer 1 offset reduction
      wr(12'h020, 32'h1234);
      rdchk("R1 t1 load", 12'h020, 32'h1234);
      rdchk("R1 t0 untouched", 12'h000, 32'h0);
      rdchk("R1 t1 bgload view", 12'h038, 32'h1234);
      rdchk("R9 t1 free narrow", 12'h024, 32'hFFFF);

      // timer 0 periodic, 32-bit, ie
      wr(12'h000, 32'd5);
      rdchk("R9 t0 free narrow reload", 12'h004, 32'hFFFF);
      wr(12'h008, 32'hE2);
      rdchk("R10 ctrl reload", 12'h004, 32'd5);
      wr(12'h004, 32'd77);
      rdchk("R7 count read-only", 12'h004, 32'd5);
      ticks(0, 3);
      rdchk("R8 three steps", 12'h004, 32'd2);
      rdchk("R5 t1 idle", 12'h024, 32'hFFFF);
      ticks(0, 2);
      rdchk("R8 at zero", 12'h004, 32'd0);
      rdchk("R8 no irq yet", 12'h010, 32'd0);
      ticks(0, 1);
      rdchk("R8 raw set", 12'h010, 32'd1);
      rdchk("R8 reloaded", 12'h004, 32'd5);
      rdchk("R11 masked", 12'h014, 32'd1);
      chk("R3 irq high", 32'(irq_any), 32'd1);
      wr(12'h00C, 32'd0);
      rdchk("R11 cleared", 12'h010, 32'd0);
      chk("R3 irq low", 32'(irq_any), 32'd0);

      // R7 background load
      wr(12'h018, 32'd9);
      rdchk("R7 bg keeps count", 12'h004, 32'd5);
      rdchk("R7 bg load view", 12'h000, 32'd9);
      ticks(0, 6);
      rdchk("R7 bg used on reload", 12'h004, 32'd9);
      wr(12'h00C, 32'd0);

      // R10 divide by 16 on timer 1, ie off
      wr(12'h020, 32'd3);
      wr(12'h028, 32'hC6);
      rdchk("R10 t1 start", 12'h024, 32'd3);
      ticks(1, 32);
      rdchk("R10 div16 two steps", 12'h024, 32'd1);
      rdchk("R5 t0 unaffected", 12'h004, 32'd9);
      ticks(1, 32);
      rdchk("R10 div16 wrap", 12'h024, 32'd3);
      rdchk("R11 t1 raw", 12'h030, 32'd1);
      rdchk("R11 t1 masked off", 12'h034, 32'd0);
      chk("R3 masked keeps low", 32'(irq_any), 32'd0);
      wr(12'h028, 32'hE6);
      chk("R3 enable raises irq", 32'(irq_any), 32'd1);
      wr(12'h02C, 32'd0);
      chk("R3 t1 cleared", 32'(irq_any), 32'd0);
      wr(12'h028, 32'h46);
      ticks(1, 40);
      rdchk("R9 disabled holds", 12'h024, 32'd3);

      // R10 divide by 256 on timer 0
      wr(12'h000, 32'd1);
      wr(12'h008, 32'hCA);
      ticks(0, 255);
      rdchk("R10 div256 before", 12'h004, 32'd1);
      ticks(0, 1);
      rdchk("R10 div256 step", 12'h004, 32'd0);
      ticks(0, 256);
      rdchk("R10 div256 wrap", 12'h004, 32'd1);
      rdchk("R10 div256 raw", 12'h010, 32'd1);
      wr(12'h00C, 32'd0);
      wr(12'h008, 32'hCE);
      ticks(0, 1);
      rdchk("R10 field 3 per tick", 12'h004, 32'd0);

      // R9 one-shot
      wr(12'h000, 32'd1);
      wr(12'h008, 32'h83);
      ticks(0, 1);
      rdchk("R9 oneshot step", 12'h004, 32'd0);
      ticks(0, 1);
      rdchk("R9 oneshot ctrl", 12'h008, 32'h03);
      rdchk("R9 oneshot raw", 12'h010, 32'd1);
      ticks(0, 3);
      rdchk("R9 oneshot holds", 12'h004, 32'd0);
      wr(12'h00C, 32'd0);

      // R9 free running wide
      wr(12'h008, 32'h82);
      rdchk("R9 free wide reload", 12'h004, 32'hFFFF_FFFF);
      ticks(0, 1);
      rdchk("R9 free wide step", 12'h004, 32'hFFFF_FFFE);
      wr(12'hFE8, 32'h0);
      rdchk("R4 id write ignored", 12'hFE8, 32'h14);
      chk("R4 no irq", 32'(irq_any), 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired got=0 exp=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule